// File: doc/BRIEF.md
# One-Shot Interval Timer with Ramp Gate

This block is a 16-bit down-counting interval timer that sits on a small byte-wide peripheral register bus and runs only in one-shot mode. Software writes the low byte of the count into a holding latch, then writes the high byte. The high-byte write moves the whole 16-bit value into the counter and starts the countdown. From then on the counter drops by one on every system clock. When it steps past zero the timer raises its interrupt flag and stops. It does not reload.

The timer also drives bit 7 of an 8-bit output port. That bit gates an external analog integrator and is active low. When the ramp-control bit of the control register is set, the pin goes low in the cycle the countdown starts and returns high when the countdown ends. The low pulse therefore lasts exactly as long as the programmed count, with no software action in between. When the ramp-control bit is clear, the pin carries whatever software last wrote to bit 7 of the port register.

Top module: `oneshot_ramp_timer`

## Requirements
- R1: After reset the flag is 0, `irq` is 0, `port_out` is 8'h80 (the ramp pin is inactive high), the counter reads 16'hFFFF and the latch reads 0.
- R2: A write to address 4 (counter low) or address 6 (latch low) updates only the low byte of the latch. It does not start the timer and does not change the counter or the pin.
- R3: A write of H to address 5 (counter high) loads the counter with {H, latch low} in the same clock edge, clears the flag and starts the countdown. H = 0 is a valid start. Address 7 updates the latch high byte without starting.
- R4: While running, the counter decreases by exactly 1 on every clock. It can be read at address 4 (low byte) and address 5 (high byte).
- R5: A count of N expires N+1 clocks after the loading edge. At expiry the flag (address 13, bit 6) is set, the timer stops, and the counter holds 16'hFFFF with no further flag events.
- R6: When control register bit 7 (address 1) is 1, port bit 7 is low for exactly N+1 clocks, starting from the loading edge, and high otherwise.
- R7: When control bit 7 is 0, port bit 7 equals bit 7 of the port register (address 0), whatever the timer is doing. Port bits 6:0 always equal the port register.
- R8: The flag is cleared by a read of address 4, or by a write to address 13 with bit 6 set. Expiry takes priority over a clear in the same cycle.
- R9: A write to address 14 with bit 6 set loads the interrupt enable from bit 7. Reading address 14 returns the enable in bit 6. `irq` equals the flag ANDed with the enable, and is also visible in bit 7 of address 13.
- R10: A counter-high write during a countdown restarts the timer with the new value, so the ramp pulse runs N'+1 clocks from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives read side effects) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| port_out | output | 8 | Output port; bit 7 is the ramp gate |
| irq | output | 1 | Timer interrupt request |

## Verification
The bench measures the ramp pulse width clock by clock, for a count of zero, a small count and a count with a non-zero high byte. An off-by-one in load or expiry shows up as a pulse one cycle short or long. A design that starts on the low-byte write would pull the pin low too early, and one that reloads would fire the flag again. Reads of the counter in the middle of a run catch a wrong decrement. The bench also covers three ways the flag can be cleared, the set/clear form of the enable register, a restart during a countdown, and the pin falling back to the software bit when ramp control is off.

// File: rtl/oneshot_ramp_timer.sv
module oneshot_ramp_timer #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] port_out,
  output logic          irq
);
  localparam int CW = 2*DW;
  localparam logic [AW-1:0] A_PORT = AW'(0);
  localparam logic [AW-1:0] A_CTL  = AW'(1);
  localparam logic [AW-1:0] A_CLO  = AW'(4);
  localparam logic [AW-1:0] A_CHI  = AW'(5);
  localparam logic [AW-1:0] A_LLO  = AW'(6);
  localparam logic [AW-1:0] A_LHI  = AW'(7);
  localparam logic [AW-1:0] A_FLG  = AW'(13);
  localparam logic [AW-1:0] A_IEN  = AW'(14);

  logic [DW-1:0] port_q, ctl_q;
  logic [CW-1:0] lat_q, cnt_q;
  logic          run_q, flag_q, ien_q;

  wire start  = wr_en && addr == A_CHI;
  wire expire = run_q && cnt_q == '0;
  wire clr_rd = rd_en && addr == A_CLO;
  wire clr_wr = wr_en && addr == A_FLG && wdata[6];
  wire ramp   = ctl_q[DW-1] ? ~run_q : port_q[DW-1];

  assign port_out = {ramp, port_q[DW-2:0]};
  assign irq      = flag_q & ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= DW'(1) << (DW-1);
      ctl_q  <= '0;
      ien_q  <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_PORT) port_q <= wdata;
      if (addr == A_CTL)  ctl_q  <= wdata;
      if (addr == A_IEN && wdata[6]) ien_q <= wdata[DW-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else if (wr_en) begin
      if (addr == A_CLO || addr == A_LLO) lat_q[DW-1:0]  <= wdata;
      if (addr == A_CHI || addr == A_LHI) lat_q[CW-1:DW] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= {wdata, lat_q[DW-1:0]};
      run_q <= 1'b1;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (expire) run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (start)            flag_q <= 1'b0;
    else if (expire)           flag_q <= 1'b1;
    else if (clr_rd || clr_wr) flag_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_PORT:  rdata = port_q;
      A_CTL:   rdata = ctl_q;
      A_CLO:   rdata = cnt_q[DW-1:0];
      A_CHI:   rdata = cnt_q[CW-1:DW];
      A_LLO:   rdata = lat_q[DW-1:0];
      A_LHI:   rdata = lat_q[CW-1:DW];
      A_FLG:   rdata = DW'({irq, flag_q}) << (DW-2);
      A_IEN:   rdata = DW'({1'b1, ien_q}) << (DW-2);
      default: rdata = '0;
    endcase
  end

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run_q && !flag_q && cnt_q == {$past(wdata), $past(lat_q[DW-1:0])}); // R3
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !start && cnt_q != '0 |=> run_q && cnt_q == $past(cnt_q) - 1'b1); // R4
  AST_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !start |=> flag_q && !run_q && cnt_q == '1); // R5
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !start |=> !run_q && $stable(cnt_q)); // R5
  AST_FLAG_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $fell(run_q)); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rd && !expire && !start |=> !flag_q); // R8
endmodule

// File: tb/test_oneshot_ramp_timer.sv
module test_oneshot_ramp_timer;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, port_out;
  logic irq;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  oneshot_ramp_timer i_oneshot_ramp_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .port_out(port_out), .irq(irq));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ramp_width(output int w);
    w = 0;
    while (port_out[7] == 1'b0 && w < 100000) begin w++; @(negedge clk); end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 flag", 32'(irq), 0);
    check("R1 port", 32'(port_out), 'h80);
    peek(4'd4, d); check("R1 cnt lo", 32'(d), 'hFF);
    peek(4'd5, d); check("R1 cnt hi", 32'(d), 'hFF);
    peek(4'd6, d); check("R1 latch", 32'(d), 0);
    peek(4'd13, d); check("R1 flag reg", 32'(d), 0);
  endtask

  task automatic t_low_write;
    logic [7:0] d;
    wr(4'd1, 8'h80);
    wr(4'd4, 8'h3C);
    repeat (3) @(negedge clk);
    check("R2 no start", 32'(port_out[7]), 1);
    peek(4'd4, d); check("R2 cnt unchanged", 32'(d), 'hFF);
    peek(4'd6, d); check("R2 latch lo", 32'(d), 'h3C);
    wr(4'd7, 8'h12);
    peek(4'd7, d); check("R3 latch hi no start", 32'(d), 'h12);
    check("R3 latch hi no start pin", 32'(port_out[7]), 1);
  endtask

  task automatic t_zero_and_small;
    int w;
    logic [7:0] d;
    wr(4'd6, 8'h00); wr(4'd5, 8'h00);
    ramp_width(w); check("R6 width N=0", w, 1);
    peek(4'd13, d); check("R5 flag N=0", 32'(d[6]), 1);
    wr(4'd6, 8'h05); wr(4'd5, 8'h00);
    peek(4'd13, d); check("R3 start clears flag", 32'(d[6]), 0);
    ramp_width(w); check("R6 width N=5 (zero hi byte)", w, 6);
    peek(4'd13, d); check("R5 flag N=5", 32'(d[6]), 1);
  endtask

  task automatic t_count_and_expire;
    logic [7:0] d;
    int w;
    wr(4'd4, 8'h2C); wr(4'd5, 8'h01);
    peek(4'd4, d); check("R3 load lo", 32'(d), 'h2C);
    peek(4'd5, d); check("R3 load hi", 32'(d), 'h01);
    repeat (50) @(negedge clk);
    peek(4'd4, d); check("R4 lo after 50", 32'(d), 'hFA);
    peek(4'd5, d); check("R4 hi after 50", 32'(d), 'h00);
    ramp_width(w); check("R6 width remainder", w, 'h12C + 1 - 50);
    peek(4'd4, d); check("R5 hold lo", 32'(d), 'hFF);
    peek(4'd5, d); check("R5 hold hi", 32'(d), 'hFF);
    wr(4'd13, 8'h40);
    repeat (20) @(negedge clk);
    peek(4'd13, d); check("R5 no re-fire", 32'(d[6]), 0);
    peek(4'd4, d); check("R5 still held", 32'(d), 'hFF);
  endtask

  task automatic t_flag_irq;
    logic [7:0] d;
    int w;
    wr(4'd14, 8'hC0);
    peek(4'd14, d); check("R9 enable readback", 32'(d[6]), 1);
    wr(4'd6, 8'h03); wr(4'd5, 8'h00);
    check("R9 irq idle during run", 32'(irq), 0);
    ramp_width(w);
    check("R9 irq on expiry", 32'(irq), 1);
    peek(4'd13, d); check("R9 irq bit", 32'(d[7]), 1);
    wr(4'd14, 8'h40);
    check("R9 irq masked", 32'(irq), 0);
    peek(4'd13, d); check("R9 flag kept", 32'(d[6]), 1);
    rd(4'd4, d);
    peek(4'd13, d); check("R8 read lo clears", 32'(d[6]), 0);
    wr(4'd14, 8'hC0);
    wr(4'd5, 8'h00); ramp_width(w);
    wr(4'd13, 8'h00);
    check("R8 write bit6=0 keeps", 32'(irq), 1);
    wr(4'd13, 8'h40);
    check("R8 write-one clears", 32'(irq), 0);
  endtask

  task automatic t_restart;
    int w;
    wr(4'd6, 8'd20); wr(4'd5, 8'h00);
    repeat (5) @(negedge clk);
    wr(4'd6, 8'd10);
    check("R10 still running", 32'(port_out[7]), 0);
    wr(4'd5, 8'h00);
    ramp_width(w); check("R10 restart width", w, 11);
  endtask

  task automatic t_manual;
    int w;
    wr(4'd1, 8'h00);
    wr(4'd0, 8'h55);
    check("R7 port follows reg", 32'(port_out), 'h55);
    wr(4'd6, 8'd8); wr(4'd5, 8'h00);
    check("R7 timer no effect", 32'(port_out[7]), 0);
    wr(4'd0, 8'hAA);
    check("R7 bit7 from reg", 32'(port_out), 'hAA);
    ramp_width(w);
    check("R7 after expiry", 32'(port_out), 'hAA);
  endtask

  initial begin
    #10000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low_write();
    t_zero_and_small();
    t_count_and_expire();
    t_flag_irq();
    t_restart();
    t_manual();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule